// File: doc/BRIEF.md
# Condition Flag and Branch Evaluator

This block keeps the four status flags of a processor datapath (zero, sign, overflow and carry) and decides whether a conditional branch is taken. When the update strobe is high at a clock edge, it recomputes the flags from the operands, the result (one bit wider than the widest operand, so the carry out is included), the operand size and the flag mode. Operands may be bytes, 16-bit words or 32-bit long words. In the arithmetic/compare mode, every flag follows the operation. In the test mode, the carry is kept, and the overflow flag doubles as a parity indicator for byte results.

The condition side takes a 4-bit condition selector and returns one taken bit. This bit is combinational from the registered flags. A branch therefore sees the flags left by the last completed update, not the ones being loaded in the same cycle. The update strobe is a plain control pin. It is never back-pressured, and every pulse is accepted at the next rising edge.

Top module: `cfe_unit`

## Requirements
- R1: A synchronous reset clears all four flags to 0 at the next rising edge. Reset takes priority over the update strobe.
- R2: The flags change only at a rising edge where `flag_load` is 1. With `flag_load` at 0, they hold whatever the other inputs do.
- R3: The zero flag is set when the result, masked to the operand size, is zero. Bits above the operand are ignored. `op_size` is 0 for 8 bits and 1 for 16 bits; both 2 and 3 select 32 bits.
- R4: The sign flag is the result bit at position size-1.
- R5: In arithmetic mode (`op_mode`=0), overflow is set when both source operands have the same sign bit (bit size-1) and the result's sign bit differs from it.
- R6: In arithmetic mode, for 8- and 16-bit sizes, carry is the result bit at position size (bit 8 or bit 16).
- R7: In arithmetic mode, for the 32-bit size, carry is set when the low 32 result bits, read as an unsigned number, exceed unsigned `src_a`. Result bit 32 is not used.
- R8: In test mode (`op_mode`=1), carry keeps its value. For an 8-bit size, overflow is loaded with the parity of result bits 7..0: it is 1 when they hold an even number of ones. For 16- and 32-bit sizes, overflow keeps its value.
- R9: `cond_taken` follows `cond_sel` as follows (Z, S, V and C are the flags):
  - 0 gives never; 8 gives always.
  - 1 gives S^V; 9 gives its inverse.
  - 2 gives Z|(S^V); 10 gives its inverse.
  - 3 gives C|Z; 11 gives its inverse.
  - 4 gives V; 12 gives !V.
  - 5 gives S; 13 gives !S.
  - 6 gives Z; 14 gives !Z.
  - 7 gives C; 15 gives !C.
- R10: `cond_taken` depends only on `cond_sel` and the registered flags. In a cycle where an update is pending, it reflects the flags from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| flag_load | input | 1 | Loads new flags at the next rising edge |
| op_mode | input | 1 | 0 selects arithmetic/compare, 1 selects test |
| op_size | input | 2 | 0 selects 8 bits, 1 selects 16 bits, 2 or 3 selects 32 bits |
| src_a | input | 32 | First source operand |
| src_b | input | 32 | Second source operand |
| result | input | 33 | Operation result, with the carry-out bit above the operand |
| cond_sel | input | 4 | Condition selector |
| z_flag | output | 1 | Zero flag |
| s_flag | output | 1 | Sign flag |
| v_flag | output | 1 | Overflow / parity flag |
| c_flag | output | 1 | Carry flag |
| cond_taken | output | 1 | Condition result from the registered flags |

## Verification
A flag update and a condition evaluation can fall in the same cycle. This happens when a branch follows straight after a flag-setting operation. To provoke it, the bench drives each new operation with `flag_load` high and a rotating condition selector in that cycle. Before the edge, it compares `cond_taken` with the value predicted from the old flags. After the edge, it sweeps all sixteen selectors against the new flags, so a design that forwarded the incoming flags, or lagged a further cycle, is caught.

// File: rtl/cfe_pkg.sv
package cfe_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE     = 2'd0,
    SZ_WORD     = 2'd1,
    SZ_LONG     = 2'd2,
    SZ_LONG_ALT = 2'd3
  } opsize_e;

  typedef enum logic {
    MODE_ARITH = 1'b0,
    MODE_TEST  = 1'b1
  } fmode_e;

  // Lower three selector bits pick a base test; bit 3 inverts it.
  typedef enum logic [2:0] {
    BC_NEVER = 3'd0,
    BC_LT    = 3'd1,
    BC_LE    = 3'd2,
    BC_ULE   = 3'd3,
    BC_OVF   = 3'd4,
    BC_MINUS = 3'd5,
    BC_ZERO  = 3'd6,
    BC_CARRY = 3'd7
  } cond_base_e;

  typedef struct packed {
    logic z;
    logic s;
    logic v;
    logic c;
  } flags_t;

  localparam int unsigned NUM_SIZE_CODES = 4;

endpackage

// File: rtl/cfe_flag_calc.sv
module cfe_flag_calc
  import cfe_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned LONG_W = 32
) (
  input  logic [1:0]        size_i,
  input  logic              mode_i,
  input  logic [LONG_W-1:0] a_i,
  input  logic [LONG_W-1:0] b_i,
  input  logic [LONG_W:0]   res_i,
  input  flags_t            cur_i,
  output flags_t            nxt_o
);

  // One lane per size code; codes 2 and 3 both get a full-width lane.
  logic [NUM_SIZE_CODES-1:0] lane_z;
  logic [NUM_SIZE_CODES-1:0] lane_s;
  logic [NUM_SIZE_CODES-1:0] lane_v;
  logic [NUM_SIZE_CODES-1:0] lane_c;
  logic                      par_even;
  logic                      unused_carry_top;
  fmode_e                    mode;
  opsize_e                   size;

  assign mode             = fmode_e'(mode_i);
  assign size             = opsize_e'(size_i);
  assign unused_carry_top = res_i[LONG_W];
  assign par_even         = ~^res_i[BYTE_W-1:0];

  for (genvar gi = 0; gi < NUM_SIZE_CODES; gi++) begin : g_lane
    localparam int unsigned W = (gi == 0) ? BYTE_W : (gi == 1) ? WORD_W : LONG_W;
    assign lane_z[gi] = (res_i[W-1:0] == '0);
    assign lane_s[gi] = res_i[W-1];
    assign lane_v[gi] = ~(a_i[W-1] ^ b_i[W-1]) & (a_i[W-1] ^ res_i[W-1]);
    if (W < LONG_W) begin : g_bitcarry
      assign lane_c[gi] = res_i[W];
    end else begin : g_cmpcarry
      assign lane_c[gi] = (res_i[LONG_W-1:0] > a_i);
    end
  end

  always_comb begin
    nxt_o.z = lane_z[size_i];
    nxt_o.s = lane_s[size_i];
    if (mode == MODE_ARITH) begin
      nxt_o.v = lane_v[size_i];
      nxt_o.c = lane_c[size_i];
    end else begin
      nxt_o.c = cur_i.c;
      nxt_o.v = (size == SZ_BYTE) ? par_even : cur_i.v;
    end
  end

endmodule

// File: rtl/cfe_flag_reg.sv
module cfe_flag_reg
  import cfe_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   load_i,
  input  flags_t nxt_i,
  output flags_t q_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_o <= '0;
    end else if (load_i) begin
      q_o <= nxt_i;
    end
  end

endmodule

// File: rtl/cfe_cond_eval.sv
module cfe_cond_eval
  import cfe_pkg::*;
(
  input  logic [3:0] sel_i,
  input  flags_t     flags_i,
  output logic       taken_o
);

  cond_base_e base_sel;
  logic       base_hit;
  logic       sgn_ne_ovf;

  assign base_sel   = cond_base_e'(sel_i[2:0]);
  assign sgn_ne_ovf = flags_i.s ^ flags_i.v;

  always_comb begin
    unique case (base_sel)
      BC_NEVER: base_hit = 1'b0;
      BC_LT:    base_hit = sgn_ne_ovf;
      BC_LE:    base_hit = flags_i.z | sgn_ne_ovf;
      BC_ULE:   base_hit = flags_i.c | flags_i.z;
      BC_OVF:   base_hit = flags_i.v;
      BC_MINUS: base_hit = flags_i.s;
      BC_ZERO:  base_hit = flags_i.z;
      BC_CARRY: base_hit = flags_i.c;
      default:  base_hit = 1'b0;
    endcase
  end

  assign taken_o = base_hit ^ sel_i[3];

endmodule

// File: rtl/cfe_unit.sv
module cfe_unit
  import cfe_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned LONG_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flag_load,
  input  logic              op_mode,
  input  logic [1:0]        op_size,
  input  logic [LONG_W-1:0] src_a,
  input  logic [LONG_W-1:0] src_b,
  input  logic [LONG_W:0]   result,
  input  logic [3:0]        cond_sel,
  output logic              z_flag,
  output logic              s_flag,
  output logic              v_flag,
  output logic              c_flag,
  output logic              cond_taken
);

  flags_t flags_q;
  flags_t flags_d;

  cfe_flag_calc #(
    .BYTE_W(BYTE_W),
    .WORD_W(WORD_W),
    .LONG_W(LONG_W)
  ) calc_i (
    .size_i(op_size),
    .mode_i(op_mode),
    .a_i   (src_a),
    .b_i   (src_b),
    .res_i (result),
    .cur_i (flags_q),
    .nxt_o (flags_d)
  );

  cfe_flag_reg reg_i (
    .clk   (clk),
    .rst   (rst),
    .load_i(flag_load),
    .nxt_i (flags_d),
    .q_o   (flags_q)
  );

  cfe_cond_eval cond_i (
    .sel_i  (cond_sel),
    .flags_i(flags_q),
    .taken_o(cond_taken)
  );

  assign z_flag = flags_q.z;
  assign s_flag = flags_q.s;
  assign v_flag = flags_q.v;
  assign c_flag = flags_q.c;

endmodule

// File: rtl/cfe_unit_chk.sv
module cfe_unit_chk #(
  parameter int unsigned BYTE_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            flag_load,
  input logic            op_mode,
  input logic [1:0]      op_size,
  input logic [BYTE_W:0] res_low,
  input logic [3:0]      cond_sel,
  input logic            z_flag,
  input logic            s_flag,
  input logic            v_flag,
  input logic            c_flag,
  input logic            cond_taken
);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> ({z_flag, s_flag, v_flag, c_flag} == 4'b0000));

  assert_hold_without_load_R2: assert property (@(posedge clk) disable iff (rst)
    !flag_load |=> $stable({z_flag, s_flag, v_flag, c_flag}));

  assert_byte_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (flag_load && op_size == 2'd0) |=> (z_flag == ($past(res_low[BYTE_W-1:0]) == '0)));

  assert_byte_carry_R6: assert property (@(posedge clk) disable iff (rst)
    (flag_load && !op_mode && op_size == 2'd0) |=> (c_flag == $past(res_low[BYTE_W])));

  assert_test_keeps_carry_R8: assert property (@(posedge clk) disable iff (rst)
    (flag_load && op_mode) |=> $stable(c_flag));

  assert_test_wide_keeps_v_R8: assert property (@(posedge clk) disable iff (rst)
    (flag_load && op_mode && op_size != 2'd0) |=> $stable(v_flag));

  assert_never_always_R9: assert property (@(posedge clk) disable iff (rst)
    (cond_sel[2:0] == 3'd0) |-> (cond_taken == cond_sel[3]));

  assert_zero_select_R9: assert property (@(posedge clk) disable iff (rst)
    (cond_sel == 4'd6) |-> (cond_taken == z_flag));

endmodule

bind cfe_unit cfe_unit_chk #(.BYTE_W(BYTE_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .flag_load (flag_load),
  .op_mode   (op_mode),
  .op_size   (op_size),
  .res_low   (result[BYTE_W:0]),
  .cond_sel  (cond_sel),
  .z_flag    (z_flag),
  .s_flag    (s_flag),
  .v_flag    (v_flag),
  .c_flag    (c_flag),
  .cond_taken(cond_taken)
);

// File: tb/cfe_unit_tb_top.sv
`timescale 1ns/1ps
module cfe_unit_tb_top;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst, flag_load, op_mode;
  logic [1:0]  op_size;
  logic [31:0] src_a, src_b;
  logic [32:0] result;
  logic [3:0]  cond_sel;
  logic        z_flag, s_flag, v_flag, c_flag, cond_taken;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int vec = 0;
  logic mz = 1'b0, ms = 1'b0, mv = 1'b0, mc = 1'b0;

  cfe_unit dut_i (
    .clk(clk), .rst(rst), .flag_load(flag_load), .op_mode(op_mode),
    .op_size(op_size), .src_a(src_a), .src_b(src_b), .result(result),
    .cond_sel(cond_sel), .z_flag(z_flag), .s_flag(s_flag), .v_flag(v_flag),
    .c_flag(c_flag), .cond_taken(cond_taken)
  );

  function automatic int width_of(logic [1:0] sz);
    return (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
  endfunction

  function automatic logic [31:0] corner(int k, int w);
    logic [31:0] m = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    logic [31:0] v;
    case (k)
      0: v = 32'd0;
      1: v = 32'd1;
      2: v = (32'd1 << (w - 1)) - 32'd1;
      3: v = 32'd1 << (w - 1);
      4: v = 32'hFFFF_FFFF;
      5: v = 32'd2;
      6: v = 32'h5A5A_5A5A;
      default: v = (32'd1 << (w - 1)) + 32'd3;
    endcase
    return v & m;
  endfunction

  function automatic logic [32:0] make_res(logic [1:0] sz, logic [31:0] a, logic [31:0] b, bit sub);
    int w = width_of(sz);
    logic [32:0] keep = (w == 32) ? {33{1'b1}} : ((33'd1 << (w + 1)) - 33'd1);
    logic [32:0] raw = sub ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
    return (raw & keep) | ~keep;
  endfunction

  function automatic bit cond_expect(logic [3:0] k);
    bit lt = ms ^ mv;
    case (k)
      4'd0:  return 1'b0;
      4'd1:  return lt;
      4'd2:  return mz | lt;
      4'd3:  return mc | mz;
      4'd4:  return mv;
      4'd5:  return ms;
      4'd6:  return mz;
      4'd7:  return mc;
      4'd8:  return 1'b1;
      4'd9:  return !lt;
      4'd10: return !(mz | lt);
      4'd11: return !(mc | mz);
      4'd12: return !mv;
      4'd13: return !ms;
      4'd14: return !mz;
      default: return !mc;
    endcase
  endfunction

  task automatic model_update(logic [1:0] sz, bit mode, logic [31:0] a, logic [31:0] b, logic [32:0] r);
    int w = width_of(sz);
    bit zz = 1'b1;
    int ones = 0;
    for (int i = 0; i < w; i++) if (r[i]) zz = 1'b0;
    mz = zz;
    ms = r[w-1];
    if (!mode) begin
      mv = (a[w-1] == b[w-1]) && (r[w-1] != a[w-1]);
      mc = (w < 32) ? r[w] : (r[31:0] > a);
    end else if (w == 8) begin
      for (int i = 0; i < 8; i++) ones += int'(r[i]);
      mv = (ones % 2 == 0);
    end
  endtask

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h (vec %0d)", tag, act, exp, vec);
    end
  endtask

  task automatic sweep_conds();
    for (int k = 0; k < 16; k++) begin
      cond_sel = 4'(k);
      #0.2;
      chk("R9", {3'b0, cond_taken}, {3'b0, cond_expect(4'(k))});
    end
  endtask

  task automatic apply(logic [1:0] sz, bit mode, logic [31:0] a, logic [31:0] b,
                       logic [32:0] r, string vtag, string ctag);
    logic [3:0] probe = 4'(vec);
    @(negedge clk);
    op_size = sz; op_mode = mode; src_a = a; src_b = b; result = r;
    flag_load = 1'b1; cond_sel = probe;
    #1;
    // R10: same-cycle evaluation still uses the old flags
    chk("R10", {3'b0, cond_taken}, {3'b0, cond_expect(probe)});
    model_update(sz, mode, a, b, r);
    @(negedge clk);
    flag_load = 1'b0;
    chk("R3", {3'b0, z_flag}, {3'b0, mz});
    chk("R4", {3'b0, s_flag}, {3'b0, ms});
    chk(vtag, {3'b0, v_flag}, {3'b0, mv});
    chk(ctag, {3'b0, c_flag}, {3'b0, mc});
    sweep_conds();
    vec++;
  endtask

  task automatic hold_probe(logic [31:0] pat);
    @(negedge clk);
    flag_load = 1'b0; op_mode = pat[0]; op_size = pat[2:1];
    src_a = pat; src_b = ~pat; result = {1'b1, pat ^ 32'h0F0F_F0F0};
    @(negedge clk);
    // R2: no load strobe, flags unchanged
    chk("R2", {z_flag, s_flag, v_flag, c_flag}, {mz, ms, mv, mc});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R10 watchdog act=running exp=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; flag_load = 1'b0; op_mode = 1'b0; op_size = 2'd0;
    src_a = '0; src_b = '0; result = '0; cond_sel = 4'd0;
    repeat (3) @(negedge clk);
    chk("R1", {z_flag, s_flag, v_flag, c_flag}, 4'b0000);
    sweep_conds();
    rst = 1'b0;

    // R5 R6 R7: arithmetic corners at every size, add and subtract
    for (int sz = 0; sz < 3; sz++) begin
      for (int ia = 0; ia < 8; ia++) begin
        for (int ib = 0; ib < 8; ib++) begin
          for (int sb = 0; sb < 2; sb++) begin
            int w = width_of(2'(sz));
            logic [31:0] a = corner(ia, w);
            logic [31:0] b = corner(ib, w);
            apply(2'(sz), 1'b0, a, b, make_res(2'(sz), a, b, sb[0]), "R5",
                  (sz == 2) ? "R7" : "R6");
          end
        end
      end
    end

    // Stepped byte operands
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 8; j++) begin
        logic [31:0] a = 32'((i * 23) & 255);
        logic [31:0] b = 32'((j * 41 + 7) & 255);
        apply(2'd0, 1'b0, a, b, make_res(2'd0, a, b, j[0]), "R5", "R6");
      end
    end

    // Size code 3 acts as 32 bits (R3, R7)
    for (int i = 0; i < 8; i++) begin
      logic [31:0] a = corner(i, 32);
      logic [31:0] b = corner(7 - i, 32);
      apply(2'd3, 1'b0, a, b, make_res(2'd3, a, b, i[0]), "R5", "R7");
    end

    // Hold behaviour after a nonzero state
    apply(2'd0, 1'b0, 32'h80, 32'h80, make_res(2'd0, 32'h80, 32'h80, 1'b0), "R5", "R6");
    for (int i = 0; i < 6; i++) hold_probe(32'h1357_9BDF * 32'(i + 1));

    // R8: test mode byte parity over all low-byte values; carry preset to 1
    apply(2'd0, 1'b0, 32'hFF, 32'h01, make_res(2'd0, 32'hFF, 32'h01, 1'b0), "R5", "R6");
    for (int v = 0; v < 256; v++) begin
      logic [32:0] r = {{25{v[0]}}, 8'(v)};
      apply(2'd0, 1'b1, 32'(v * 3), 32'(v * 5), r, "R8", "R8");
    end

    // R8: test mode on wide sizes keeps overflow and carry
    for (int i = 0; i < 16; i++) begin
      logic [1:0] sz = (i < 8) ? 2'd1 : 2'd2;
      logic [31:0] a = corner(i % 8, 16);
      if (i % 4 == 0)
        apply(sz, 1'b0, a, corner(3, 16), make_res(sz, a, corner(3, 16), i[2]), "R5",
              (sz == 2'd2) ? "R7" : "R6");
      apply(sz, 1'b1, a, 32'd0, {1'b1, corner(i % 8, width_of(sz)) ^ 32'h00F0_0000}, "R8", "R8");
    end

    // R1: mid-run reset beats a pending load
    apply(2'd0, 1'b0, 32'h80, 32'h80, make_res(2'd0, 32'h80, 32'h80, 1'b0), "R5", "R6");
    @(negedge clk);
    rst = 1'b1; flag_load = 1'b1; op_size = 2'd0; op_mode = 1'b0; result = 33'h1_0000_0100;
    @(negedge clk);
    rst = 1'b0; flag_load = 1'b0;
    mz = 1'b0; ms = 1'b0; mv = 1'b0; mc = 1'b0;
    chk("R1", {z_flag, s_flag, v_flag, c_flag}, 4'b0000);
    sweep_conds();

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule